// File: doc/BRIEF.md
# Security-Filtering Peripheral Bridge

This block sits between a simple memory-mapped request port and a two-phase peripheral bus. Each upstream request carries an address, a write flag, write data and a non-secure flag. The peripheral bus has no way to carry that flag, so the bridge enforces access rights itself before any peripheral is selected.

The bridge owns a window of `N_SLOTS` peripheral slots. Each slot is `2**SLOT_AW` bytes and the window starts at `BASE_ADDR`. One static input bit per slot says whether that slot is secure. A non-secure request to a secure slot is refused. An address outside the window gets a decode error. In both cases no peripheral select is raised.

Allowed requests run one setup cycle and then an access phase that lasts until the peripheral signals ready. The result comes back upstream as a one-cycle done pulse with an error flag and read data.

The controller has four states:
- `ST_IDLE` waits for a request.
- `ST_SETUP` drives the select.
- `ST_ACCESS` adds the enable and waits for ready.
- `ST_RESP` presents the response.

The transitions are:
- `ST_IDLE`→`ST_SETUP` when a request is allowed.
- `ST_IDLE`→`ST_RESP` when a request is refused or decodes to no slot.
- `ST_SETUP`→`ST_ACCESS` always.
- `ST_ACCESS`→`ST_ACCESS` while ready is low.
- `ST_ACCESS`→`ST_RESP` on ready.
- `ST_RESP`→`ST_IDLE` always.

The requester holds `up_valid` and its request fields steady until it sees `up_done`, then drops `up_valid`.

Top module: `secure_periph_bridge`

## Requirements
- R1: After reset, `p_sel`, `p_enable` and `up_done` are all 0.
- R2: A request whose bits [31:15] equal `BASE_ADDR` bits [31:15] targets slot `up_addr[14:12]`. That slot is at bit position k of `p_sel`. Only that bit is ever set, and `p_addr` carries `up_addr[11:0]`.
- R3: An address outside the window completes with `up_err`=1 and `up_rdata`=0, and no bit of `p_sel` is ever set.
- R4: A request with `up_ns`=1 to a slot whose `slot_secure` bit is 1 completes with `up_err`=1 and `up_rdata`=0, and no bit of `p_sel` is ever set.
- R5: A request with `up_ns`=0 reaches its slot whether that slot is secure or not.
- R6: A request with `up_ns`=1 to a slot whose `slot_secure` bit is 0 reaches that slot.
- R7: An allowed transfer has one cycle with the select high and `p_enable` low. The next cycles have both high until `p_ready` is 1. Select, `p_addr`, `p_write` and `p_wdata` stay stable while waiting.
- R8: A refused or undecoded request raises `up_done` in the first cycle after the edge that accepts it.
- R9: An allowed access with no wait states raises `up_done` three cycles after acceptance, plus one cycle per wait state. A read without error returns the `p_rdata` value seen with `p_ready`.
- R10: If `p_slverr` is 1 when `p_ready` is 1, the response has `up_err`=1 and `up_rdata`=0.
- R11: `up_done` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_secure | input | N_SLOTS | Per-slot secure marking, 1 = secure |
| up_valid | input | 1 | Request present, held until done |
| up_write | input | 1 | 1 = write, 0 = read |
| up_ns | input | 1 | 1 = non-secure requester |
| up_addr | input | ADDR_W | Request address |
| up_wdata | input | DATA_W | Write data |
| up_done | output | 1 | Response pulse |
| up_err | output | 1 | Error response (refused, undecoded or slave error) |
| up_rdata | output | DATA_W | Read data, 0 on error |
| p_sel | output | N_SLOTS | One-hot peripheral select |
| p_enable | output | 1 | Access phase enable |
| p_write | output | 1 | Peripheral write flag |
| p_addr | output | SLOT_AW | Offset within the slot |
| p_wdata | output | DATA_W | Peripheral write data |
| p_rdata | input | DATA_W | Peripheral read data |
| p_ready | input | 1 | Peripheral ready |
| p_slverr | input | 1 | Peripheral error |

## Verification
The assertions check on every cycle that:
- the select is one-hot or idle;
- enable never appears without a select and is always preceded by a setup cycle;
- the bus holds steady while ready is low;
- a non-secure requester never selects a secure slot;
- error responses carry zero data;
- done never lasts two cycles.

Other behaviour is visible only in the directed scenarios:
- which slot a given address selects;
- that secure requesters reach every slot;
- the exact response latency for refused and waited transfers;
- that read data and slave errors are passed back correctly.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RESP   = 2'd3
    } bridge_state_e;
endpackage

// File: rtl/slot_decoder.sv
`timescale 1ns/1ps
module slot_decoder #(
    parameter int          ADDR_W    = 32,
    parameter int          N_SLOTS   = 8,
    parameter int          SLOT_AW   = 12,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [N_SLOTS-1:0] sel_onehot
);
    localparam int IDX_W      = $clog2(N_SLOTS);
    localparam int REGION_LSB = SLOT_AW + IDX_W;

    logic [IDX_W-1:0] idx;

    assign hit = (addr[ADDR_W-1:REGION_LSB] == BASE_ADDR[ADDR_W-1:REGION_LSB]);
    assign idx = addr[REGION_LSB-1:SLOT_AW];

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_sel
        assign sel_onehot[k] = hit && (idx == IDX_W'(k));
    end
endmodule

// File: rtl/access_gate.sv
`timescale 1ns/1ps
module access_gate #(
    parameter int N_SLOTS = 8
) (
    input  logic               hit,
    input  logic [N_SLOTS-1:0] sel_onehot,
    input  logic [N_SLOTS-1:0] slot_secure,
    input  logic               ns,
    output logic               allow
);
    logic target_secure;

    assign target_secure = |(sel_onehot & slot_secure);
    assign allow         = hit && !(ns && target_secure);
endmodule

// File: rtl/secure_periph_bridge.sv
`timescale 1ns/1ps
module secure_periph_bridge #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          N_SLOTS   = 8,
    parameter int          SLOT_AW   = 12,
    parameter logic [31:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] slot_secure,
    input  logic               up_valid,
    input  logic               up_write,
    input  logic               up_ns,
    input  logic [ADDR_W-1:0]  up_addr,
    input  logic [DATA_W-1:0]  up_wdata,
    output logic               up_done,
    output logic               up_err,
    output logic [DATA_W-1:0]  up_rdata,
    output logic [N_SLOTS-1:0] p_sel,
    output logic               p_enable,
    output logic               p_write,
    output logic [SLOT_AW-1:0] p_addr,
    output logic [DATA_W-1:0]  p_wdata,
    input  logic [DATA_W-1:0]  p_rdata,
    input  logic               p_ready,
    input  logic               p_slverr
);
    import bridge_pkg::*;

    bridge_state_e state, nxt;

    logic               dec_hit;
    logic [N_SLOTS-1:0] dec_sel;
    logic               allow;

    logic [N_SLOTS-1:0] sel_q;
    logic [SLOT_AW-1:0] off_q;
    logic               write_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               err_q;
    logic [DATA_W-1:0]  data_q;

    slot_decoder #(
        .ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS), .SLOT_AW(SLOT_AW), .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr(up_addr), .hit(dec_hit), .sel_onehot(dec_sel)
    );

    access_gate #(.N_SLOTS(N_SLOTS)) u_gate (
        .hit(dec_hit), .sel_onehot(dec_sel), .slot_secure(slot_secure),
        .ns(up_ns), .allow(allow)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request capture and response datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            off_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            err_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (state == ST_IDLE && up_valid) begin
                sel_q   <= allow ? dec_sel : '0;
                off_q   <= up_addr[SLOT_AW-1:0];
                write_q <= up_write;
                wdata_q <= up_wdata;
                err_q   <= !allow;
                data_q  <= '0;
            end else if (state == ST_ACCESS && p_ready) begin
                err_q  <= p_slverr;
                data_q <= (!write_q && !p_slverr) ? p_rdata : '0;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt      = state;
        p_sel    = '0;
        p_enable = 1'b0;
        up_done  = 1'b0;
        up_err   = 1'b0;
        up_rdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (up_valid) nxt = allow ? ST_SETUP : ST_RESP;
            end
            ST_SETUP: begin
                p_sel = sel_q;
                nxt   = ST_ACCESS;
            end
            ST_ACCESS: begin
                p_sel    = sel_q;
                p_enable = 1'b1;
                if (p_ready) nxt = ST_RESP;
            end
            ST_RESP: begin
                up_done  = 1'b1;
                up_err   = err_q;
                up_rdata = data_q;
                nxt      = ST_IDLE;
            end
        endcase
    end

    assign p_write = write_q;
    assign p_addr  = off_q;
    assign p_wdata = wdata_q;
endmodule

// File: rtl/bridge_checker.sv
`timescale 1ns/1ps
module bridge_checker #(
    parameter int DATA_W  = 32,
    parameter int N_SLOTS = 8,
    parameter int SLOT_AW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SLOTS-1:0] slot_secure,
    input logic               up_valid,
    input logic               up_ns,
    input logic               up_done,
    input logic               up_err,
    input logic [DATA_W-1:0]  up_rdata,
    input logic [N_SLOTS-1:0] p_sel,
    input logic               p_enable,
    input logic [SLOT_AW-1:0] p_addr,
    input logic               p_write,
    input logic [DATA_W-1:0]  p_wdata,
    input logic               p_ready
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_sel)); // R2

    AST_ENABLE_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        p_enable |-> (p_sel != '0)); // R7

    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (p_enable && !$past(p_enable)) |-> ($past(p_sel) != '0)); // R7

    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (p_enable && !p_ready) |=> (p_enable && $stable(p_sel) && $stable(p_addr)
                                    && $stable(p_write) && $stable(p_wdata))); // R7

    AST_NO_SECURE_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ns) |-> ((p_sel & slot_secure) == '0)); // R4

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (up_done && up_err) |-> (up_rdata == '0)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> !up_done); // R11
endmodule

bind secure_periph_bridge bridge_checker #(
    .DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .SLOT_AW(SLOT_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_secure(slot_secure), .up_valid(up_valid),
    .up_ns(up_ns), .up_done(up_done), .up_err(up_err), .up_rdata(up_rdata),
    .p_sel(p_sel), .p_enable(p_enable), .p_addr(p_addr), .p_write(p_write),
    .p_wdata(p_wdata), .p_ready(p_ready)
);

// File: tb/test_secure_periph_bridge.sv
`timescale 1ns/1ps
module test_secure_periph_bridge;
    localparam int AW = 32, DW = 32, NS_ = 8, SAW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS_-1:0]  slot_secure = 8'b0000_0110;   // slots 1 and 2 secure
    logic            up_valid = 1'b0, up_write = 1'b0, up_ns = 1'b0;
    logic [AW-1:0]   up_addr = '0;
    logic [DW-1:0]   up_wdata = '0;
    logic            up_done, up_err;
    logic [DW-1:0]   up_rdata;
    logic [NS_-1:0]  p_sel;
    logic            p_enable, p_write;
    logic [SAW-1:0]  p_addr;
    logic [DW-1:0]   p_wdata, p_rdata;
    logic            p_ready, p_slverr;

    int errors = 0, checks = 0;
    int wait_n = 0;
    int wcnt = 0;
    logic [SAW-1:0] obs_addr;
    logic           obs_write;
    logic [DW-1:0]  obs_wdata;

    always #4 clk = ~clk;

    secure_periph_bridge i_secure_periph_bridge (
        .clk(clk), .rst_n(rst_n), .slot_secure(slot_secure), .up_valid(up_valid),
        .up_write(up_write), .up_ns(up_ns), .up_addr(up_addr), .up_wdata(up_wdata),
        .up_done(up_done), .up_err(up_err), .up_rdata(up_rdata), .p_sel(p_sel),
        .p_enable(p_enable), .p_write(p_write), .p_addr(p_addr), .p_wdata(p_wdata),
        .p_rdata(p_rdata), .p_ready(p_ready), .p_slverr(p_slverr)
    );

    // Peripheral model: data encodes slot and offset, error at offset 0xFFC
    logic [7:0] sel_idx;
    always_comb begin
        sel_idx = 8'hFF;
        for (int k = 0; k < NS_; k++) if (p_sel[k]) sel_idx = 8'(k);
    end
    assign p_rdata  = 32'hA500_0000 | ({24'h0, sel_idx} << 16) | {20'h0, p_addr};
    assign p_ready  = p_enable && (wcnt >= wait_n);
    assign p_slverr = p_ready && (p_addr == 12'hFFC);
    always @(posedge clk) begin
        if (p_enable && !p_ready) wcnt <= wcnt + 1;
        else                      wcnt <= 0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] addr, input bit wr, input logic [31:0] wd,
                        input bit ns, input int wt, input bit exp_err,
                        input logic [31:0] exp_rd, input logic [7:0] exp_sel,
                        input int exp_cyc, input string req);
        logic [7:0] sel_or = '0;
        int cyc = 0;
        bit prev_en = 0, prev_sel = 0, setup_ok = 1;
        wait_n = wt;
        @(negedge clk);
        up_addr = addr; up_write = wr; up_wdata = wd; up_ns = ns; up_valid = 1'b1;
        while (cyc < 50) begin
            @(negedge clk);
            cyc++;
            sel_or |= p_sel;
            if (p_enable && !prev_en && !prev_sel) setup_ok = 0;
            if (p_enable && p_ready) begin
                obs_addr = p_addr; obs_write = p_write; obs_wdata = p_wdata;
            end
            prev_en = p_enable; prev_sel = (p_sel != 0);
            if (up_done) break;
        end
        check(up_err == exp_err, req, "error flag", 32'(up_err), 32'(exp_err));
        check(up_rdata == exp_rd, req, "read data", up_rdata, exp_rd);
        check(sel_or == exp_sel, req, "selects seen", 32'(sel_or), 32'(exp_sel));
        check(cyc == exp_cyc, req, "done latency", 32'(cyc), 32'(exp_cyc));
        check(setup_ok, "R7", "setup before access", 32'(setup_ok), 32'd1);
        up_valid = 1'b0;
        @(negedge clk);
        check(up_done == 1'b0, "R11", "done single pulse", 32'(up_done), 32'd0);
    endtask

    task automatic t_reset();
        check(p_sel == 0, "R1", "reset sel", 32'(p_sel), 0);
        check(p_enable == 0, "R1", "reset enable", 32'(p_enable), 0);
        check(up_done == 0, "R1", "reset done", 32'(up_done), 0);
    endtask

    task automatic t_secure_reads();
        // R5: secure requester reaches secure slot 2 and non-secure slot 0; R9 zero waits
        xfer(32'h4000_2024, 0, 0, 0, 0, 0, 32'hA502_0024, 8'h04, 3, "R5");
        xfer(32'h4000_0008, 0, 0, 0, 0, 0, 32'hA500_0008, 8'h01, 3, "R9");
    endtask

    task automatic t_ns_allowed();
        // R6 with two wait states: latency 3 + 2
        xfer(32'h4000_5100, 0, 0, 1, 2, 0, 32'hA505_0100, 8'h20, 5, "R6");
    endtask

    task automatic t_refused();
        // R4, R8: non-secure to secure slots 2 and 1
        xfer(32'h4000_2000, 1, 32'h1234, 1, 0, 1, 0, 8'h00, 1, "R4");
        xfer(32'h4000_1010, 0, 0, 1, 0, 1, 0, 8'h00, 1, "R8");
    endtask

    task automatic t_decode_miss();
        xfer(32'h4000_8000, 0, 0, 0, 0, 1, 0, 8'h00, 1, "R3");
        xfer(32'h3FFF_FFFC, 1, 32'h55, 0, 0, 1, 0, 8'h00, 1, "R3");
    endtask

    task automatic t_write_path();
        xfer(32'h4000_7010, 1, 32'hDEAD_BEEF, 0, 1, 0, 0, 8'h80, 4, "R2");
        check(obs_addr == 12'h010, "R2", "peripheral offset", 32'(obs_addr), 32'h010);
        check(obs_write == 1'b1, "R7", "peripheral write flag", 32'(obs_write), 1);
        check(obs_wdata == 32'hDEAD_BEEF, "R7", "peripheral wdata", obs_wdata, 32'hDEAD_BEEF);
    endtask

    task automatic t_slverr();
        xfer(32'h4000_1FFC, 0, 0, 0, 0, 1, 0, 8'h02, 3, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_secure_reads();
        t_ns_allowed();
        t_refused();
        t_decode_miss();
        t_write_path();
        t_slverr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule